// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a small processor that completes one instruction in every clock cycle. Each cycle it presents the program counter on a read-only instruction port and receives the 32-bit instruction word in the same cycle. It then decodes the word, reads up to two operands from a 32-entry register bank, computes a result, and writes that result back at the next clock edge. Loads and stores use a word-wide data port. Its address, write data and strobes come straight from the current instruction, and read data must return within the same cycle.

The core is a building block for a controller or test sequencer. Both memory ports are plain combinational request/response paths with no valid/ready pairing. The core never stalls, and the memories cannot apply back-pressure. An instruction memory or data memory attached to it must answer within the cycle. A slower memory has to gate the clock or hold reset. Accesses narrower than a word are handled outside this block.

Top module: `scalar_core`

## Requirements
- R1: Register 0 reads as zero on both operand ports. Any instruction that targets it leaves it at zero, and this includes lui, addi, lw and R-format writes.
- R2: Opcode 0x00 is the R-format: op[31:26] rs[25:21] rt[20:16] rd[15:11] shamt[10:6] funct[5:0]. The following funct codes write rd: 0x20 writes rs+rt, 0x22 writes rs-rt, 0x24 writes rs AND rt, 0x25 writes rs OR rt, and 0x26 writes rs XOR rt.
- R3: funct 0x00 writes rt shifted left by shamt into rd. funct 0x02 writes rt shifted right by shamt into rd, filling with zeros.
- R4: funct 0x2A writes 1 to rd when rs < rt as signed two's-complement values, and writes 0 otherwise.
- R5: I-format is op rs rt imm[15:0], and the result goes to rt. Opcode 0x08 adds the sign-extended imm to rs. Opcode 0x0D ORs rs with the zero-extended imm. Opcode 0x0F writes imm into bits 31..16 and zeros into bits 15..0.
- R6: For loads (0x23) and stores (0x2B), the data address is rs + sign-extended imm. A store drives the rt value on the write data with the write strobe high. A load drives the read strobe high and writes the returned word to rt.
- R7: Opcode 0x04 branches when rs equals rt, and opcode 0x05 branches when they differ. A taken branch sets the PC to PC+4 + 4*sext(imm). A branch that is not taken goes to PC+4.
- R8: Opcode 0x02 jumps to {PC+4[31:28], target[25:0], 00}. Opcode 0x03 does the same and also writes PC+4 into register 31.
- R9: R-format funct 0x08 loads the PC from rs and writes no register.
- R10: While reset is asserted, the PC is 0 and all registers are cleared. Every instruction that is not a branch or a jump advances the PC by 4.
- R11: Any opcode or R-format funct not listed above acts as a no-op. It writes no register, makes no memory access and advances the PC by 4.
- R12: The write and read strobes are never high together. Only loads and stores raise either strobe, and no write is issued while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Program counter, byte address of the current instruction |
| imem_rdata | input | 32 | Instruction word at imem_addr, same cycle |
| dmem_addr | output | 32 | Data byte address for a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, the write takes effect at the rising edge |
| dmem_re | output | 1 | Load strobe |
| dmem_rdata | input | 32 | Load data for dmem_addr, same cycle |

## Verification
The bench builds the core with its default parameters: 32-bit words, 32 registers and a reset PC of zero. The register numbers, the link register 31 and the shift amounts up to 31 therefore appear exactly as the instruction fields encode them. With these values, sign-bit operands such as 0x80000041 and negative branch offsets are within reach of short programs, along with the shift edges at 0, 4 and 31. Small memories of 64 words in the bench cover backward loops, calls and returns, and loads and stores that use negative offsets.

// File: rtl/scalar_core_pkg.sv
`timescale 1ns/1ps
package scalar_core_pkg;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_J     = 6'h02;
  localparam logic [5:0] OP_JAL   = 6'h03;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_BNE   = 6'h05;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_LUI   = 6'h0F;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;

  localparam logic [5:0] FN_SLL = 6'h00;
  localparam logic [5:0] FN_SRL = 6'h02;
  localparam logic [5:0] FN_JR  = 6'h08;
  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_XOR = 6'h26;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR,
    ALU_SLL, ALU_SRL, ALU_SLT, ALU_PASSB
  } alu_op_e;

  typedef enum logic [1:0] {OPB_REG, OPB_SEXT, OPB_ZEXT, OPB_HIGH} opb_sel_e;
  typedef enum logic [1:0] {DST_RD, DST_RT, DST_LINK} dst_sel_e;
  typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_LINK} wb_sel_e;
  typedef enum logic [2:0] {NX_SEQ, NX_BEQ, NX_BNE, NX_JUMP, NX_REG} next_sel_e;

  typedef struct packed {
    logic      reg_we;
    dst_sel_e  dst;
    wb_sel_e   wb;
    alu_op_e   alu;
    opb_sel_e  opb;
    logic      mem_rd;
    logic      mem_wr;
    next_sel_e nxt;
  } ctrl_t;

endpackage

// File: rtl/scalar_core_regs.sv
`timescale 1ns/1ps
module scalar_core_regs #(
  parameter int W = 32,
  parameter int N = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rsel_a,
  input  logic [AW-1:0] rsel_b,
  output logic [W-1:0]  rval_a,
  output logic [W-1:0]  rval_b,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_sel,
  input  logic [W-1:0]  wr_val
);

  logic [N-1:0][W-1:0] bank_q;

  // entry 0 is never written; the read muxes force it to zero as well
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
    end else if (wr_en && (wr_sel != '0)) begin
      bank_q[wr_sel] <= wr_val;
    end
  end

  assign rval_a = (rsel_a == '0) ? '0 : bank_q[rsel_a];
  assign rval_b = (rsel_b == '0) ? '0 : bank_q[rsel_b];

endmodule

// File: rtl/scalar_core_alu.sv
`timescale 1ns/1ps
module scalar_core_alu
  import scalar_core_pkg::*;
#(
  parameter int W = 32,
  localparam int SW = $clog2(W)
) (
  input  alu_op_e       op,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic [SW-1:0] shamt,
  output logic [W-1:0]  y
);

  always_comb begin
    case (op)
      ALU_ADD:   y = a + b;
      ALU_SUB:   y = a - b;
      ALU_AND:   y = a & b;
      ALU_OR:    y = a | b;
      ALU_XOR:   y = a ^ b;
      ALU_SLL:   y = b << shamt;
      ALU_SRL:   y = b >> shamt;
      ALU_SLT:   y = W'($signed(a) < $signed(b));
      ALU_PASSB: y = b;
      default:   y = '0;
    endcase
  end

endmodule

// File: rtl/scalar_core_decode.sv
`timescale 1ns/1ps
module scalar_core_decode
  import scalar_core_pkg::*;
(
  input  logic [31:0] instr,
  output ctrl_t       ctrl
);

  logic [5:0] opc;
  logic [5:0] fn;

  assign opc = instr[31:26];
  assign fn  = instr[5:0];

  always_comb begin
    ctrl     = '0;
    ctrl.dst = DST_RD;
    ctrl.wb  = WB_ALU;
    ctrl.alu = ALU_ADD;
    ctrl.opb = OPB_REG;
    ctrl.nxt = NX_SEQ;
    case (opc)
      OP_RTYPE: begin
        ctrl.reg_we = 1'b1;
        case (fn)
          FN_ADD: ctrl.alu = ALU_ADD;
          FN_SUB: ctrl.alu = ALU_SUB;
          FN_AND: ctrl.alu = ALU_AND;
          FN_OR:  ctrl.alu = ALU_OR;
          FN_XOR: ctrl.alu = ALU_XOR;
          FN_SLL: ctrl.alu = ALU_SLL;
          FN_SRL: ctrl.alu = ALU_SRL;
          FN_SLT: ctrl.alu = ALU_SLT;
          FN_JR: begin
            ctrl.reg_we = 1'b0;
            ctrl.nxt    = NX_REG;
          end
          default: ctrl.reg_we = 1'b0;
        endcase
      end
      OP_ADDI: begin
        ctrl.reg_we = 1'b1;
        ctrl.dst    = DST_RT;
        ctrl.opb    = OPB_SEXT;
      end
      OP_ORI: begin
        ctrl.reg_we = 1'b1;
        ctrl.dst    = DST_RT;
        ctrl.alu    = ALU_OR;
        ctrl.opb    = OPB_ZEXT;
      end
      OP_LUI: begin
        ctrl.reg_we = 1'b1;
        ctrl.dst    = DST_RT;
        ctrl.alu    = ALU_PASSB;
        ctrl.opb    = OPB_HIGH;
      end
      OP_LW: begin
        ctrl.reg_we = 1'b1;
        ctrl.dst    = DST_RT;
        ctrl.wb     = WB_MEM;
        ctrl.opb    = OPB_SEXT;
        ctrl.mem_rd = 1'b1;
      end
      OP_SW: begin
        ctrl.opb    = OPB_SEXT;
        ctrl.mem_wr = 1'b1;
      end
      OP_BEQ: ctrl.nxt = NX_BEQ;
      OP_BNE: ctrl.nxt = NX_BNE;
      OP_J:   ctrl.nxt = NX_JUMP;
      OP_JAL: begin
        ctrl.nxt    = NX_JUMP;
        ctrl.reg_we = 1'b1;
        ctrl.dst    = DST_LINK;
        ctrl.wb     = WB_LINK;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/scalar_core_pc.sv
`timescale 1ns/1ps
module scalar_core_pc
  import scalar_core_pkg::*;
#(
  parameter int          W        = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  next_sel_e    nxt,
  input  logic         ops_equal,
  input  logic [15:0]  offset,
  input  logic [25:0]  target,
  input  logic [W-1:0] reg_target,
  output logic [W-1:0] pc,
  output logic [W-1:0] pc_plus4
);

  logic [W-1:0] pc_q;
  logic [W-1:0] pc_d;
  logic [W-1:0] br_dest;
  logic [W-1:0] jmp_dest;

  assign pc_plus4 = pc_q + W'(4);
  assign br_dest  = pc_plus4 + {{(W-18){offset[15]}}, offset, 2'b00};
  assign jmp_dest = {pc_plus4[W-1:28], target, 2'b00};

  always_comb begin
    case (nxt)
      NX_BEQ:  pc_d = ops_equal  ? br_dest : pc_plus4;
      NX_BNE:  pc_d = !ops_equal ? br_dest : pc_plus4;
      NX_JUMP: pc_d = jmp_dest;
      NX_REG:  pc_d = reg_target;
      default: pc_d = pc_plus4;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= W'(RESET_PC);
    else        pc_q <= pc_d;
  end

  assign pc = pc_q;

endmodule

// File: rtl/scalar_core.sv
`timescale 1ns/1ps
module scalar_core
  import scalar_core_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          NREGS    = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] imem_addr,
  input  logic [31:0]     imem_rdata,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  output logic            dmem_re,
  input  logic [XLEN-1:0] dmem_rdata
);

  localparam int RAW  = $clog2(NREGS);
  localparam int SW   = $clog2(XLEN);
  localparam int LINK = NREGS - 1;

  ctrl_t           ctrl;
  logic [RAW-1:0]  f_rs, f_rt, f_rd, wr_sel;
  logic [15:0]     f_imm;
  logic [XLEN-1:0] rs_val, rt_val, opnd_b, alu_y, wr_val, pc, pc_plus4;

  assign f_rs  = imem_rdata[21 +: RAW];
  assign f_rt  = imem_rdata[16 +: RAW];
  assign f_rd  = imem_rdata[11 +: RAW];
  assign f_imm = imem_rdata[15:0];

  scalar_core_decode u_dec (
    .instr (imem_rdata),
    .ctrl  (ctrl)
  );

  always_comb begin
    case (ctrl.dst)
      DST_RT:   wr_sel = f_rt;
      DST_LINK: wr_sel = RAW'(LINK);
      default:  wr_sel = f_rd;
    endcase
    case (ctrl.opb)
      OPB_SEXT: opnd_b = {{(XLEN-16){f_imm[15]}}, f_imm};
      OPB_ZEXT: opnd_b = {{(XLEN-16){1'b0}}, f_imm};
      OPB_HIGH: opnd_b = {f_imm, {(XLEN-16){1'b0}}};
      default:  opnd_b = rt_val;
    endcase
    case (ctrl.wb)
      WB_MEM:  wr_val = dmem_rdata;
      WB_LINK: wr_val = pc_plus4;
      default: wr_val = alu_y;
    endcase
  end

  scalar_core_regs #(.W(XLEN), .N(NREGS)) u_rf (
    .clk    (clk),
    .rst_n  (rst_n),
    .rsel_a (f_rs),
    .rsel_b (f_rt),
    .rval_a (rs_val),
    .rval_b (rt_val),
    .wr_en  (ctrl.reg_we),
    .wr_sel (wr_sel),
    .wr_val (wr_val)
  );

  scalar_core_alu #(.W(XLEN)) u_alu (
    .op    (ctrl.alu),
    .a     (rs_val),
    .b     (opnd_b),
    .shamt (SW'(imem_rdata[10:6])),
    .y     (alu_y)
  );

  scalar_core_pc #(.W(XLEN), .RESET_PC(RESET_PC)) u_pc (
    .clk        (clk),
    .rst_n      (rst_n),
    .nxt        (ctrl.nxt),
    .ops_equal  (rs_val == rt_val),
    .offset     (f_imm),
    .target     (imem_rdata[25:0]),
    .reg_target (rs_val),
    .pc         (pc),
    .pc_plus4   (pc_plus4)
  );

  assign imem_addr  = pc;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctrl.mem_wr & rst_n;
  assign dmem_re    = ctrl.mem_rd;

endmodule

// File: rtl/scalar_core_chk.sv
`timescale 1ns/1ps
module scalar_core_chk
  import scalar_core_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input logic            clk,
  input logic            rst_n,
  input logic [XLEN-1:0] imem_addr,
  input logic [31:0]     imem_rdata,
  input logic            dmem_we,
  input logic            dmem_re,
  input logic [XLEN-1:0] rs_val,
  input logic [XLEN-1:0] rt_val
);

  logic [5:0]      opc;
  logic            is_jr, is_ctl, is_mem;
  logic [XLEN-1:0] seq_pc, br_pc, jmp_pc;

  assign opc    = imem_rdata[31:26];
  assign is_jr  = (opc == OP_RTYPE) && (imem_rdata[5:0] == FN_JR);
  assign is_ctl = is_jr || (opc == OP_J) || (opc == OP_JAL) ||
                  (opc == OP_BEQ) || (opc == OP_BNE);
  assign is_mem = (opc == OP_LW) || (opc == OP_SW);
  assign seq_pc = imem_addr + XLEN'(4);
  assign br_pc  = seq_pc + {{(XLEN-18){imem_rdata[15]}}, imem_rdata[15:0], 2'b00};
  assign jmp_pc = {seq_pc[XLEN-1:28], imem_rdata[25:0], 2'b00};

  // R10
  pc_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> imem_addr == XLEN'(RESET_PC));

  // R10 R11
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_ctl |=> imem_addr == $past(seq_pc));

  // R7
  br_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((opc == OP_BEQ && rs_val == rt_val) || (opc == OP_BNE && rs_val != rt_val))
    |=> imem_addr == $past(br_pc));

  // R8
  jump_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == OP_J || opc == OP_JAL) |=> imem_addr == $past(jmp_pc));

  // R9
  jr_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_jr |=> imem_addr == $past(rs_val));

  // R1
  zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_rdata[25:21] == 5'd0) |-> rs_val == '0);

  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dmem_we && dmem_re));

  // R12
  strobe_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_mem |-> (!dmem_we && !dmem_re));

  // R6
  store_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == OP_SW) |-> dmem_we);

endmodule

bind scalar_core scalar_core_chk #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .imem_addr  (imem_addr),
  .imem_rdata (imem_rdata),
  .dmem_we    (dmem_we),
  .dmem_re    (dmem_re),
  .rs_val     (rs_val),
  .rt_val     (rt_val)
);

// File: tb/scalar_core_bench.sv
`timescale 1ns/1ps
module scalar_core_bench;

  localparam logic [5:0] C_J = 6'h02, C_JAL = 6'h03, C_BEQ = 6'h04, C_BNE = 6'h05;
  localparam logic [5:0] C_ADDI = 6'h08, C_ORI = 6'h0D, C_LUI = 6'h0F;
  localparam logic [5:0] C_LW = 6'h23, C_SW = 6'h2B;
  localparam logic [5:0] F_SLL = 6'h00, F_SRL = 6'h02, F_JR = 6'h08, F_ADD = 6'h20;
  localparam logic [5:0] F_SUB = 6'h22, F_AND = 6'h24, F_OR = 6'h25, F_XOR = 6'h26;
  localparam logic [5:0] F_SLT = 6'h2A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, dmem_re;
  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  int          n_chk = 0;
  int          n_fail = 0;
  int          both_cnt = 0;

  always #10 clk = ~clk;

  scalar_core u_scalar_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_re    (dmem_re),
    .dmem_rdata (dmem_rdata)
  );

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
  always @(negedge clk) if (rst_n && dmem_we && dmem_re) both_cnt++;

  function automatic logic [31:0] rr(logic [5:0] fn, logic [4:0] rs, logic [4:0] rt,
                                     logic [4:0] rd, logic [4:0] sh);
    return {6'h00, rs, rt, rd, sh, fn};
  endfunction
  function automatic logic [31:0] ii(logic [5:0] op, logic [4:0] rs, logic [4:0] rt,
                                     logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction
  function automatic logic [31:0] jj(logic [5:0] op, int word);
    logic [31:0] byte_addr = 32'(word * 4);
    return {op, byte_addr[27:2]};
  endfunction
  function automatic logic [15:0] boff(int from, int to);
    return 16'(to - (from + 1));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic begin_prog();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 64; i++) begin
      imem[i] = 32'h0;
      dmem[i] = 32'h0;
    end
  endtask

  task automatic release_rst();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    begin_prog();
    imem[0] = ii(C_SW, 5'd0, 5'd0, 16'h0080);
    imem[1] = jj(C_J, 1);
    @(negedge clk);
    chk("R10 pc in reset", imem_addr, 32'h0);
    chk("R12 no write in reset", {31'b0, dmem_we}, 32'h0);
    release_rst();
    chk("R10 first fetch", imem_addr, 32'h0);
    @(negedge clk);
    chk("R10 pc step", imem_addr, 32'h4);
    chk("R12 store strobe only", {31'b0, dmem_re}, 32'h0);
  endtask

  task automatic t_arith();
    begin_prog();
    imem[0] = ii(C_ADDI, 5'd0, 5'd1, 16'd5);
    imem[1] = ii(C_ADDI, 5'd0, 5'd2, 16'hFFFD);
    imem[2] = ii(C_ORI, 5'd0, 5'd5, 16'hF00F);
    imem[3] = rr(F_ADD, 5'd1, 5'd2, 5'd3, 5'd0);
    imem[4] = rr(F_SUB, 5'd2, 5'd1, 5'd4, 5'd0);
    imem[5] = rr(F_AND, 5'd2, 5'd5, 5'd6, 5'd0);
    imem[6] = rr(F_OR,  5'd2, 5'd5, 5'd7, 5'd0);
    imem[7] = rr(F_XOR, 5'd2, 5'd5, 5'd8, 5'd0);
    imem[8]  = ii(C_SW, 5'd0, 5'd2, 16'h0080);
    imem[9]  = ii(C_SW, 5'd0, 5'd3, 16'h0084);
    imem[10] = ii(C_SW, 5'd0, 5'd4, 16'h0088);
    imem[11] = ii(C_SW, 5'd0, 5'd6, 16'h008C);
    imem[12] = ii(C_SW, 5'd0, 5'd7, 16'h0090);
    imem[13] = ii(C_SW, 5'd0, 5'd8, 16'h0094);
    imem[14] = ii(C_SW, 5'd0, 5'd5, 16'h0098);
    imem[15] = jj(C_J, 15);
    release_rst();
    repeat (24) @(negedge clk);
    chk("R5 addi sign-extend", dmem[32], -32'sd3);
    chk("R2 add", dmem[33], 32'd5 + (-32'sd3));
    chk("R2 sub", dmem[34], (-32'sd3) - 32'd5);
    chk("R2 and", dmem[35], 32'hFFFF_FFFD & 32'h0000_F00F);
    chk("R2 or",  dmem[36], 32'hFFFF_FFFD | 32'h0000_F00F);
    chk("R2 xor", dmem[37], 32'hFFFF_FFFD ^ 32'h0000_F00F);
    chk("R5 ori zero-extend", dmem[38], 32'h0000_F00F);
  endtask

  task automatic t_shift_slt();
    begin_prog();
    imem[0] = ii(C_LUI, 5'd0, 5'd1, 16'h8000);
    imem[1] = ii(C_ORI, 5'd1, 5'd1, 16'h0041);
    imem[2] = rr(F_SRL, 5'd0, 5'd1, 5'd2, 5'd4);
    imem[3] = rr(F_SLL, 5'd0, 5'd1, 5'd3, 5'd31);
    imem[4] = rr(F_SLT, 5'd1, 5'd0, 5'd4, 5'd0);
    imem[5] = rr(F_SLT, 5'd0, 5'd1, 5'd5, 5'd0);
    imem[6] = ii(C_ADDI, 5'd0, 5'd6, 16'd1);
    imem[7] = rr(F_SLT, 5'd0, 5'd6, 5'd7, 5'd0);
    imem[8] = ii(C_ADDI, 5'd0, 5'd8, 16'hFFFF);
    imem[9] = ii(C_LUI, 5'd0, 5'd8, 16'h1234);
    imem[10] = rr(F_SLL, 5'd0, 5'd1, 5'd9, 5'd0);
    imem[11] = ii(C_SW, 5'd0, 5'd1, 16'h0080);
    imem[12] = ii(C_SW, 5'd0, 5'd2, 16'h0084);
    imem[13] = ii(C_SW, 5'd0, 5'd3, 16'h0088);
    imem[14] = ii(C_SW, 5'd0, 5'd4, 16'h008C);
    imem[15] = ii(C_SW, 5'd0, 5'd5, 16'h0090);
    imem[16] = ii(C_SW, 5'd0, 5'd7, 16'h0094);
    imem[17] = ii(C_SW, 5'd0, 5'd8, 16'h0098);
    imem[18] = ii(C_SW, 5'd0, 5'd9, 16'h009C);
    imem[19] = jj(C_J, 19);
    release_rst();
    repeat (28) @(negedge clk);
    chk("R5 lui then ori", dmem[32], 32'h8000_0041);
    chk("R3 srl zero fill", dmem[33], 32'h8000_0041 >> 4);
    chk("R3 sll by 31", dmem[34], 32'h8000_0041 << 31);
    chk("R4 slt negative < 0", dmem[35], 32'd1);
    chk("R4 slt 0 < negative", dmem[36], 32'd0);
    chk("R4 slt 0 < 1", dmem[37], 32'd1);
    chk("R5 lui clears low half", dmem[38], 32'h1234_0000);
    chk("R3 sll by 0", dmem[39], 32'h8000_0041);
  endtask

  task automatic t_zero();
    begin_prog();
    imem[0] = ii(C_ADDI, 5'd0, 5'd0, 16'd7);
    imem[1] = ii(C_LUI, 5'd0, 5'd0, 16'hABCD);
    imem[2] = rr(F_ADD, 5'd0, 5'd0, 5'd0, 5'd0);
    imem[3] = ii(C_ADDI, 5'd0, 5'd2, 16'd7);
    imem[4] = rr(F_OR, 5'd2, 5'd2, 5'd0, 5'd0);
    imem[5] = ii(C_LW, 5'd0, 5'd0, 16'h00C0);
    imem[6] = ii(C_ADDI, 5'd0, 5'd1, 16'd0);
    imem[7] = ii(C_SW, 5'd0, 5'd0, 16'h0080);
    imem[8] = ii(C_SW, 5'd0, 5'd1, 16'h0084);
    imem[9] = ii(C_SW, 5'd0, 5'd2, 16'h0088);
    imem[10] = jj(C_J, 10);
    release_rst();
    dmem[48] = 32'h5A5A_5A5A;
    repeat (16) @(negedge clk);
    chk("R1 r0 stored", dmem[32], 32'h0);
    chk("R1 r0 as source", dmem[33], 32'h0);
    chk("R1 companion write", dmem[34], 32'd7);
  endtask

  task automatic t_mem();
    begin_prog();
    imem[0] = ii(C_ADDI, 5'd0, 5'd1, 16'h0040);
    imem[1] = ii(C_ADDI, 5'd0, 5'd2, 16'h1234);
    imem[2] = ii(C_LUI, 5'd0, 5'd3, 16'hDEAD);
    imem[3] = ii(C_ORI, 5'd3, 5'd3, 16'hBEEF);
    imem[4] = ii(C_SW, 5'd1, 5'd2, 16'hFFFC);
    imem[5] = ii(C_SW, 5'd1, 5'd3, 16'h0008);
    imem[6] = ii(C_LW, 5'd1, 5'd4, 16'hFFFC);
    imem[7] = ii(C_LW, 5'd1, 5'd5, 16'h0008);
    imem[8] = ii(C_SW, 5'd0, 5'd4, 16'h0080);
    imem[9] = ii(C_SW, 5'd0, 5'd5, 16'h0084);
    imem[10] = jj(C_J, 10);
    release_rst();
    repeat (6) @(negedge clk);
    chk("R6 load strobe", {30'b0, dmem_re, dmem_we}, 32'h2);
    chk("R6 load address", dmem_addr, 32'h3C);
    repeat (10) @(negedge clk);
    chk("R6 store negative offset", dmem[15], 32'h1234);
    chk("R6 store positive offset", dmem[18], 32'hDEAD_BEEF);
    chk("R6 load back a", dmem[32], 32'h1234);
    chk("R6 load back b", dmem[33], 32'hDEAD_BEEF);
  endtask

  task automatic t_branch();
    begin_prog();
    imem[0] = ii(C_ADDI, 5'd0, 5'd1, 16'd3);
    imem[1] = ii(C_ADDI, 5'd2, 5'd2, 16'd1);
    imem[2] = ii(C_ADDI, 5'd1, 5'd1, 16'hFFFF);
    imem[3] = ii(C_BNE, 5'd1, 5'd0, boff(3, 1));
    imem[4] = ii(C_BEQ, 5'd0, 5'd0, boff(4, 6));
    imem[5] = ii(C_ADDI, 5'd0, 5'd3, 16'h0055);
    imem[6] = ii(C_BNE, 5'd0, 5'd0, boff(6, 8));
    imem[7] = ii(C_ADDI, 5'd0, 5'd4, 16'h0066);
    imem[8] = ii(C_BEQ, 5'd1, 5'd2, boff(8, 10));
    imem[9] = ii(C_ADDI, 5'd0, 5'd6, 16'h0077);
    imem[10] = ii(C_SW, 5'd0, 5'd2, 16'h0080);
    imem[11] = ii(C_SW, 5'd0, 5'd3, 16'h0084);
    imem[12] = ii(C_SW, 5'd0, 5'd4, 16'h0088);
    imem[13] = ii(C_SW, 5'd0, 5'd6, 16'h008C);
    imem[14] = jj(C_J, 14);
    release_rst();
    repeat (4) @(negedge clk);
    chk("R7 bne backward taken", imem_addr, 32'h4);
    repeat (30) @(negedge clk);
    chk("R7 loop count", dmem[32], 32'd3);
    chk("R7 beq taken skips", dmem[33], 32'd0);
    chk("R7 bne not taken", dmem[34], 32'h66);
    chk("R7 beq not taken", dmem[35], 32'h77);
  endtask

  task automatic t_call();
    begin_prog();
    imem[0] = ii(C_ADDI, 5'd0, 5'd5, 16'd1);
    imem[1] = jj(C_JAL, 8);
    imem[2] = ii(C_SW, 5'd0, 5'd5, 16'h0080);
    imem[3] = ii(C_SW, 5'd0, 5'd31, 16'h0084);
    imem[4] = ii(C_ADDI, 5'd0, 5'd7, 16'd48);
    imem[5] = rr(F_JR, 5'd7, 5'd0, 5'd0, 5'd0);
    imem[6] = ii(C_ADDI, 5'd0, 5'd5, 16'h0099);
    imem[8] = ii(C_ADDI, 5'd5, 5'd5, 16'h0020);
    imem[9] = rr(F_JR, 5'd31, 5'd0, 5'd0, 5'd0);
    imem[12] = ii(C_SW, 5'd0, 5'd5, 16'h0088);
    imem[13] = jj(C_J, 13);
    release_rst();
    repeat (2) @(negedge clk);
    chk("R8 jal target", imem_addr, 32'h20);
    repeat (2) @(negedge clk);
    chk("R9 jr return", imem_addr, 32'h8);
    repeat (12) @(negedge clk);
    chk("R8 call body ran", dmem[32], 32'h21);
    chk("R8 link value", dmem[33], 32'h8);
    chk("R9 jr via other register", dmem[34], 32'h21);
  endtask

  task automatic t_unknown();
    begin_prog();
    imem[0] = ii(C_ADDI, 5'd0, 5'd1, 16'h0011);
    imem[1] = ii(6'h3F, 5'd0, 5'd1, 16'hFFFF);
    imem[2] = rr(6'h3F, 5'd0, 5'd0, 5'd1, 5'd0);
    imem[3] = ii(C_SW, 5'd0, 5'd1, 16'h0080);
    imem[4] = jj(C_J, 4);
    release_rst();
    @(negedge clk);
    chk("R11 no strobe on unknown op", {30'b0, dmem_re, dmem_we}, 32'h0);
    @(negedge clk);
    chk("R11 pc advances", imem_addr, 32'h8);
    repeat (6) @(negedge clk);
    chk("R11 register untouched", dmem[32], 32'h11);
    chk("R12 strobes never together", 32'(both_cnt), 32'd0);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_arith();
    t_shift_slt();
    t_zero();
    t_mem();
    t_branch();
    t_call();
    t_unknown();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule